// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked control front end of a flow-through synchronous burst SRAM with a small internal array. On each rising clock edge it samples three chip enables, two address strobes, an advance input, the write controls and the write data. From these it classifies the cycle as one of five kinds: a deselect, a new read, a new read-or-write, a continued burst or a suspended burst. It then drives byte-lane-masked writes into the array.

Read data is flow-through. The array is read combinationally from the registered address, so a word is presented in the same cycle its address is captured. No extra pipeline stage is added. An asynchronous output enable, together with the write and select state, decides whether the data lines are driven.

The two low address bits come from a two-bit burst counter. A static mode pin picks the burst order: a wrapping count, or an exclusive-or sequence. Every access completes in one clock, so the data pins carry no handshake and apply no back-pressure. A new word may be presented or returned on every cycle.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An access start (processor strobe low with `en_lo_n` low, or controller strobe low) selects the device only when `en_lo_n`=0, `en_aux_n`=0 and `en_hi`=1. A start that is not selected gives `rdata_oe`=0, and no array write takes place until the next selected start.
- R2: When `en_lo_n` is high, a low processor strobe is ignored, and the cycle is decoded from the other strobe and the advance input.
- R3: A processor-strobe start is always a read of the new external address, whatever the write controls are.
- R4: A controller-strobe start (with no processor-strobe start) captures the external address. It is a write or a read according to the write controls.
- R5: With no start, `adv_n`=0 moves to the next burst address. The cycle reads or writes according to the write controls.
- R6: With no start, `adv_n`=1 keeps the current address. The cycle reads or writes according to the write controls.
- R7: Only the two low address bits change within a burst. At step k (0..3) from start low bits b, they are (b+k) mod 4 when `mode_lin`=1, and b XOR k when `mode_lin`=0.
- R8: A write happens when `wr_all_n`=0, or when `wr_en_n`=0 and some `lane_we_n` bit is 0; otherwise the cycle is a read. `wr_all_n`=0 writes all four 9-bit lanes. Otherwise lane n (data bits 9n+8..9n) is written when `lane_we_n[n]`=0.
- R9: Read data is flow-through. After the edge that captures or advances a selected read address, the word stored there appears on `rdata` in that same cycle, with `rdata_oe`=1 when `oe_n`=0.
- R10: `oe_n` acts with no clock. While it is high, `rdata_oe`=0 and `rdata` is zero.
- R11: After a processor-strobe read start, a wait cycle (`adv_n`=1) with the write controls asserted writes the same address.
- R12: After reset, the device is deselected and `rdata_oe`=0.
- R13: During a cycle sampled as a write, `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_lo_n | input | 1 | Active-low chip enable; also gates the processor strobe |
| en_aux_n | input | 1 | Second active-low chip enable |
| en_hi | input | 1 | Active-high chip enable |
| strb_proc_n | input | 1 | Processor address strobe, active low; always starts a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low; read or write start |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| addr | input | AW | External word address |
| wr_all_n | input | 1 | Global write, active low, all lanes |
| wr_en_n | input | 1 | Lane write enable, active low |
| lane_we_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*9 | Write data, lane n in bits 9n+8..9n |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mode_lin | input | 1 | Burst order: 1 wrapping count, 0 exclusive-or |
| rdata | output | LANES*9 | Read data, zero when not driven |
| rdata_oe | output | 1 | Data driver enable |

## Verification
A behavioural reference model runs beside the design and is compared on every clock. Directed patterns then separate the decode paths. Four-beat bursts from a start address with low bits 01 produce different sequences in the two orders, so swapped or mis-wrapped counters show up. Processor starts with write controls asserted, strobes with `en_lo_n` high, and unselected starts followed by write attempts each show whether the gating and the held select state are honoured. Single-lane writes, lane selects without the enable, and write-after-read on a wait cycle confirm the lane mask and the address used. Toggling `oe_n` with no clock edge confirms the output gate is asynchronous.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    ACC_SUSPEND    = 2'd0,
    ACC_ADVANCE    = 2'd1,
    ACC_PROC_START = 2'd2,
    ACC_CTL_START  = 2'd3
  } acc_kind_e;

  // Low two address bits at a given burst step.
  function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                              input logic [1:0] step,
                                              input logic       linear);
    return linear ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_lo_n,
  input  logic             en_aux_n,
  input  logic             en_hi,
  input  logic             strb_proc_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             sel_q,
  output acc_kind_e        kind,
  output logic             start,
  output logic             sel_next,
  output logic             wr_next,
  output logic [LANES-1:0] mask_next
);

  logic             sel_now;
  logic             wr_any;
  logic [LANES-1:0] mask_in;

  assign sel_now = !en_lo_n && !en_aux_n && en_hi;

  always_comb begin
    if (!strb_proc_n && !en_lo_n) kind = ACC_PROC_START;
    else if (!strb_ctl_n)         kind = ACC_CTL_START;
    else if (!adv_n)              kind = ACC_ADVANCE;
    else                          kind = ACC_SUSPEND;
  end

  assign start = (kind == ACC_PROC_START) || (kind == ACC_CTL_START);

  // Merged write decode: global write, or lane enable with any lane selected.
  always_comb begin
    if (!wr_all_n)     mask_in = '1;
    else if (!wr_en_n) mask_in = ~lane_we_n;
    else               mask_in = '0;
  end
  assign wr_any = |mask_in;

  assign sel_next  = start ? sel_now : sel_q;
  assign wr_next   = (kind != ACC_PROC_START) && sel_next && wr_any;
  assign mask_next = wr_next ? mask_in : '0;

endmodule

// File: rtl/sbc_burst.sv
module sbc_burst
  import sbc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] ext_addr,
  input  logic          mode_lin,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      step_q <= '0;
    end else if (advance) begin
      step_q <= step_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], step_q, mode_lin)};

  a_r4_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (load && $stable(mode_lin)) |=> (cur_addr == $past(ext_addr)));

  a_r5_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance) |=> (step_q == $past(step_q) + 2'd1));

  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(cur_addr) || !$stable(mode_lin)));

  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sbc_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_lo_n,
  input  logic                    en_aux_n,
  input  logic                    en_hi,
  input  logic                    strb_proc_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic [AW-1:0]           addr,
  input  logic                    wr_all_n,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    mode_lin,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DW = LANES * LANE_W;

  acc_kind_e        kind;
  logic             start;
  logic             sel_next;
  logic             wr_next;
  logic [LANES-1:0] mask_next;

  logic             sel_q;
  logic             wr_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    wdata_q;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    arr_rd;
  logic             drive;

  sbc_decode #(.LANES(LANES)) u_decode (
    .en_lo_n    (en_lo_n),
    .en_aux_n   (en_aux_n),
    .en_hi      (en_hi),
    .strb_proc_n(strb_proc_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .wr_all_n   (wr_all_n),
    .wr_en_n    (wr_en_n),
    .lane_we_n  (lane_we_n),
    .sel_q      (sel_q),
    .kind       (kind),
    .start      (start),
    .sel_next   (sel_next),
    .wr_next    (wr_next),
    .mask_next  (mask_next)
  );

  sbc_burst #(.AW(AW)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .advance (kind == ACC_ADVANCE),
    .ext_addr(addr),
    .mode_lin(mode_lin),
    .cur_addr(cur_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      sel_q   <= sel_next;
      wr_q    <= wr_next;
      mask_q  <= mask_next;
      wdata_q <= wdata;
    end
  end

  // Self-timed write lands on the edge after the cycle was registered.
  sbc_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .we   (mask_q),
    .waddr(cur_addr),
    .wdata(wdata_q),
    .raddr(cur_addr),
    .rdata(arr_rd)
  );

  assign drive    = sel_q && !wr_q && !oe_n;
  assign rdata_oe = drive;
  assign rdata    = drive ? arr_rd : '0;

  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((!strb_proc_n && !en_lo_n) || !strb_ctl_n) && !(!en_lo_n && !en_aux_n && en_hi))
      |=> !rdata_oe);

  a_r1_no_write_desel: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (mask_q == '0));

  a_r3_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !en_lo_n) |=> (mask_q == '0));

  a_r13_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> !rdata_oe);

  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdata_oe && rdata == '0));

endmodule

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;

  localparam int AW = 6;
  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_lo_n = 1'b0, en_aux_n = 1'b0, en_hi = 1'b1;
  logic strb_proc_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wr_all_n = 1'b1, wr_en_n = 1'b1;
  logic [3:0] lane_we_n = 4'hF;
  logic [DW-1:0] wdata = '0;
  logic oe_n = 1'b0, mode_lin = 1'b1;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R12";

  always #2.5 clk = ~clk;

  burst_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_lo_n(en_lo_n), .en_aux_n(en_aux_n), .en_hi(en_hi),
    .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .addr(addr),
    .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_we_n(lane_we_n), .wdata(wdata),
    .oe_n(oe_n), .mode_lin(mode_lin), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // Reference model
  logic [DW-1:0] mmem [DEPTH];
  bit            m_sel, m_wr;
  logic [3:0]    m_mask;
  logic [DW-1:0] m_wd;
  int            m_base, m_k;

  function automatic int m_addr();
    int lo;
    if (mode_lin) lo = ((m_base % 4) + m_k) % 4;
    else          lo = (m_base % 4) ^ m_k;
    return (m_base / 4) * 4 + lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_wr = 0; m_mask = 0; m_wd = 0; m_base = 0; m_k = 0;
    end else begin
      bit wreq;
      logic [3:0] min;
      int a;
      a = m_addr();
      if (m_sel && m_wr)
        for (int l = 0; l < 4; l++)
          if (m_mask[l]) mmem[a][l*9 +: 9] = m_wd[l*9 +: 9];
      min  = !wr_all_n ? 4'hF : (!wr_en_n ? ~lane_we_n : 4'h0);
      wreq = (min != 0);
      if (!strb_proc_n && !en_lo_n) begin
        m_sel = !en_aux_n && en_hi; m_base = int'(addr); m_k = 0; m_wr = 0;
      end else if (!strb_ctl_n) begin
        m_sel = !en_lo_n && !en_aux_n && en_hi; m_base = int'(addr); m_k = 0;
        m_wr = m_sel && wreq;
      end else begin
        if (!adv_n) m_k = (m_k + 1) % 4;
        m_wr = m_sel && wreq;
      end
      m_mask = m_wr ? min : 4'h0;
      m_wd = wdata;
    end
  end

  function automatic logic [DW-1:0] pat(int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1;
    return {4'(i), v};
  endfunction

  task automatic compare();
    bit eo;
    logic [DW-1:0] ed;
    eo = m_sel && !m_wr && !oe_n;
    ed = eo ? mmem[m_addr()] : '0;
    checks++;
    if (rdata_oe !== eo || rdata !== ed) begin
      errors++;
      $display("FAIL %s cycle: oe=%0b data=%h expected oe=%0b data=%h",
               cur_req, rdata_oe, rdata, eo, ed);
    end
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic idle();
    en_lo_n = 0; en_aux_n = 0; en_hi = 1;
    strb_proc_n = 1; strb_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_en_n = 1; lane_we_n = 4'hF;
  endtask

  task automatic ctl_start(int a, bit wr, logic [DW-1:0] d);
    idle(); strb_ctl_n = 0; addr = AW'(a); wr_all_n = !wr; wdata = d;
  endtask

  task automatic proc_start(int a);
    idle(); strb_proc_n = 0; addr = AW'(a);
  endtask

  initial begin
    logic [DW-1:0] exp;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R12";
    chk("R12", {35'd0, rdata_oe}, 36'd0);
    rst_n = 1;
    step();

    // Fill the array with full-word controller writes.
    cur_req = "R4";
    for (int i = 0; i < DEPTH; i++) begin
      ctl_start(i, 1, pat(i));
      step();
      chk("R13", {35'd0, rdata_oe}, 36'd0);
    end
    idle(); step();

    // Single controller reads.
    cur_req = "R9";
    ctl_start(10, 0, '0); step(); chk("R9", rdata, pat(10));
    ctl_start(63, 0, '0); step(); chk("R4", rdata, pat(63));

    // Linear burst from 5: 5,6,7,4.
    cur_req = "R7";
    mode_lin = 1;
    proc_start(5); step(); chk("R3", rdata, pat(5));
    idle(); adv_n = 0;
    step(); chk("R5", rdata, pat(6));
    step(); chk("R7", rdata, pat(7));
    step(); chk("R7", rdata, pat(4));
    // Exclusive-or burst from 5: 5,4,7,6.
    mode_lin = 0;
    proc_start(5); step(); chk("R7", rdata, pat(5));
    idle(); adv_n = 0;
    step(); chk("R7", rdata, pat(4));
    step(); chk("R7", rdata, pat(7));
    step(); chk("R7", rdata, pat(6));
    mode_lin = 1;

    // Suspend keeps the address.
    cur_req = "R6";
    proc_start(33); step();
    idle(); step(); chk("R6", rdata, pat(33));
    step(); chk("R6", rdata, pat(33));

    // Processor start with write controls asserted still reads.
    cur_req = "R3";
    proc_start(40); wr_all_n = 0; wdata = 36'h0_DEAD_BEEF; step();
    chk("R3", {35'd0, rdata_oe}, 36'd1);
    chk("R3", rdata, pat(40));

    // Write on the following wait cycle at the same address.
    cur_req = "R11";
    idle(); wr_all_n = 0; wdata = 36'hA_1234_5678; step();
    chk("R13", {35'd0, rdata_oe}, 36'd0);
    idle(); step(); chk("R11", rdata, 36'hA_1234_5678);

    // Single-lane write: lane 1 only.
    cur_req = "R8";
    ctl_start(20, 0, 36'hF_FFFF_FFFF); wr_en_n = 0; lane_we_n = 4'b1101; step();
    idle(); step();
    exp = pat(20); exp[17:9] = 9'h1FF;
    ctl_start(20, 0, '0); step(); chk("R8", rdata, exp);
    // Lane selects without the enable: a read, nothing written.
    ctl_start(21, 0, 36'h0); lane_we_n = 4'h0; step();
    chk("R8", rdata, pat(21));
    idle(); step();
    ctl_start(21, 0, '0); step(); chk("R8", rdata, pat(21));

    // Burst write with advance: 8,9 written.
    cur_req = "R5";
    ctl_start(8, 1, 36'h1_1111_1111); step();
    idle(); adv_n = 0; wr_all_n = 0; wdata = 36'h2_2222_2222; step();
    idle(); step();
    ctl_start(9, 0, '0); step(); chk("R5", rdata, 36'h2_2222_2222);
    ctl_start(8, 0, '0); step(); chk("R5", rdata, 36'h1_1111_1111);

    // Unselected start blocks following writes.
    cur_req = "R1";
    ctl_start(44, 1, 36'h3_3333_3333); en_hi = 0; step();
    chk("R1", {35'd0, rdata_oe}, 36'd0);
    idle(); wr_all_n = 0; wdata = 36'h4_4444_4444; step();
    idle(); adv_n = 0; wr_all_n = 0; step();
    idle(); step();
    chk("R1", {35'd0, rdata_oe}, 36'd0);
    ctl_start(44, 0, '0); step(); chk("R1", rdata, pat(44));
    ctl_start(45, 0, '0); step(); chk("R1", rdata, pat(45));
    // Processor strobe with en_aux_n high deselects.
    proc_start(46); en_aux_n = 1; step();
    chk("R1", {35'd0, rdata_oe}, 36'd0);

    // Processor strobe ignored while en_lo_n is high.
    cur_req = "R2";
    ctl_start(12, 0, '0); step(); chk("R2", rdata, pat(12));
    idle(); en_lo_n = 1; strb_proc_n = 0; addr = 6'd50; step();
    chk("R2", rdata, pat(12));
    idle(); en_lo_n = 1; strb_proc_n = 0; adv_n = 0; addr = 6'd50; step();
    chk("R2", rdata, pat(13));

    // Output enable acts without a clock.
    cur_req = "R10";
    idle(); ctl_start(30, 0, '0); step();
    idle();
    @(negedge clk);
    oe_n = 1; #0.5;
    chk("R10", {rdata, rdata_oe}, 37'd0);
    oe_n = 0; #0.5;
    chk("R10", {rdata, rdata_oe}, {pat(30), 1'b1});
    step();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule